// File: doc/BRIEF.md
# Serial Flash Buffer-Program Command Front End

This block is the device side of a serial flash that accepts SPI mode-0 traffic. It collects serial bits into bytes and decodes two commands. The first writes data into one of two page-sized SRAM buffers and then programs that buffer into a main-memory page. The second erases the whole array. Address fields are split differently for the two page-size modes. The standard mode uses 264-byte pages and the binary mode uses 256-byte pages. The buffer write pointer wraps inside the page.

A program or erase is launched only when chip select rises after a complete and valid command. The work is self-timed. A page program first walks the addressed page writing all-ones, then copies the selected buffer into it. Each phase lasts a parameterised number of clock cycles, and the status byte reports busy for the whole sequence. The main array is a small behavioural RAM with a combinational read port. The page index is taken modulo the number of modelled pages. The write-protect input is sampled only while the device is idle, so protection raised during an operation takes effect only after that operation ends.

Top module: `serflash_bufprog`

## Requirements
- R1: Bits are taken MSB first on rising `sck` while `cs_n` is low. Opcode 0x82 targets buffer 1 and opcode 0x85 targets buffer 2. Each is followed by three address bytes, and every byte after them is data.
- R2: With `page_bin`=0 the page holds 264 bytes. Of the 24 address bits, bits 20..9 are the page and bits 8..0 are the starting buffer byte.
- R3: With `page_bin`=1 the page holds 256 bytes. Bits 19..8 are the page and bits 7..0 are the starting buffer byte.
- R4: Data bytes go to consecutive buffer bytes. After the last byte of the page the pointer wraps to byte 0. A starting byte at or beyond the page size starts at byte 0.
- R5: A rise of `cs_n` after all three address bytes first erases the page to 0xFF and then copies the first page-size bytes of the selected buffer into it. The page index used is the page number modulo NUM_PAGES.
- R6: After a program launch, `status[7]` reads 0 for exactly ERASE_CYC+PROG_CYC clock cycles and reads 1 otherwise.
- R7: The exact byte sequence 0xC7 0x94 0x80 0x9A followed by a rise of `cs_n` sets every byte of the array to 0xFF. It keeps `status[7]` at 0 for exactly CHIP_CYC cycles.
- R8: Any other sequence that begins with 0xC7 has no effect on the array or on the status.
- R9: A rise of `cs_n` before the third address byte has been received programs nothing and leaves the status ready.
- R10: A command started while busy is ignored. It writes no buffer byte, launches nothing and does not change the length of the running operation.
- R11: `wp_n` low is sampled only while idle. Once sampled it sets `status[1]`, and every later program or chip-erase launch is refused (buffer writes still happen). Sampling a high `wp_n` while idle clears `status[1]`.
- R12: `status` is {ready, 5'b0, protect, page_bin}, so it reads 0x80 after reset with `page_bin`=0 and `wp_n`=1. Bit 0 follows `page_bin`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; serial inputs are oversampled on it |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock, mode 0 |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in |
| wp_n | input | 1 | Write protect, active low |
| page_bin | input | 1 | Page-size mode: 1 = 256-byte, 0 = 264-byte |
| rd_page | input | PG_W | Main-array read page index |
| rd_byte | input | 9 | Main-array read byte index |
| rd_data | output | 8 | Main-array read data |
| status | output | 8 | Status byte {ready, 0, 0, 0, 0, 0, protect, page_bin} |

## Verification
Programs are sent in both page modes with page numbers whose top bit is set. This tells a correct field split from one shifted by a bit. The vectors include starts near the page end in each mode, so a wrap at 256 can be told from a wrap at 264, and one start lies beyond the page. Both buffers are first filled completely, so every byte of a programmed page is known and a buffer mix-up shows up. Further cases cover a chip-erase sequence with one wrong byte, a truncated address, a command overlapping a busy period, and write protect raised mid-operation. Each of these distinguishes a block that ignores the command from one that acts on part of it.

// File: rtl/serflash_pkg.sv
// Shared constants and state types for the serial flash command front end.
// Assumes byte-wide serial commands and two page buffers.
package serflash_pkg;
    localparam logic [7:0] OP_PROG_B1 = 8'h82;
    localparam logic [7:0] OP_PROG_B2 = 8'h85;
    localparam logic [7:0] OP_CE0     = 8'hC7;
    localparam logic [7:0] OP_CE1     = 8'h94;
    localparam logic [7:0] OP_CE2     = 8'h80;
    localparam logic [7:0] OP_CE3     = 8'h9A;

    localparam int PAGE_STD = 264;
    localparam int PAGE_BIN = 256;

    typedef enum logic [2:0] {
        D_OPC, D_ADDR, D_DATA, D_CHIP, D_CHIP_OK, D_SKIP
    } dec_st_t;

    typedef enum logic [1:0] {
        E_IDLE, E_ERASE, E_PROG, E_CHIP
    } eng_st_t;
endpackage

// File: rtl/serflash_sync.sv
// Multi-stage synchroniser for asynchronous serial pins.
// Assumes each bit is independent; reset loads RST_VAL into every stage.
module serflash_sync #(
    parameter int W = 4,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // first stage samples the raw pins
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= RST_VAL;
                else        stg[s] <= d;
            end
        end else begin : g_next
            // later stages settle the value
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= RST_VAL;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/serflash_byte_rx.sv
// Assembles MSB-first serial bits into bytes on each sampled SCK rise.
// Assumes sck_rise is a one-cycle pulse; the bit counter clears while deselected.
module serflash_byte_rx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_active,
    input  logic       sck_rise,
    input  logic       si,
    output logic       byte_vld,
    output logic [7:0] byte_q
);
    logic [2:0] bit_cnt;
    logic [7:0] shreg;

    // shift in one bit per SCK rise, flag every eighth bit
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_active) begin
            bit_cnt  <= '0;
            shreg    <= '0;
            byte_vld <= 1'b0;
        end else begin
            byte_vld <= 1'b0;
            if (sck_rise) begin
                shreg   <= {shreg[6:0], si};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) byte_vld <= 1'b1;
            end
        end
    end

    assign byte_q = shreg;

    // R1: a byte is only reported right after a sampled clock edge
    p_byte_on_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> $past(sck_rise));
endmodule

// File: rtl/serflash_decode.sv
// Command decoder: opcode match, address split per page mode, buffer pointer
// with wrap, chip-erase sequence match, and launch on chip-select rise.
// Assumes page_bin is static while a command is in progress.
module serflash_decode
    import serflash_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_active,
    input  logic        cs_rise,
    input  logic        byte_vld,
    input  logic [7:0]  byte_q,
    input  logic        page_bin,
    input  logic        busy,
    input  logic        prot,
    output logic        buf_we,
    output logic        buf_sel,
    output logic [8:0]  buf_idx,
    output logic [7:0]  buf_wdata,
    output logic        prog_go,
    output logic        chip_go,
    output logic        go_sel,
    output logic [11:0] go_page
);
    dec_st_t     st;
    logic [1:0]  acnt;
    logic [12:0] addr_sh;
    logic [8:0]  ptr;
    logic [1:0]  ce_idx;
    logic [8:0]  page_len;
    logic [8:0]  last_idx;
    logic [11:0] dec_page;
    logic [8:0]  dec_start;
    logic [7:0]  ce_expect;

    assign page_len = page_bin ? 9'(PAGE_BIN) : 9'(PAGE_STD);
    assign last_idx = page_len - 9'd1;

    // split the address once the third byte arrives (addr_sh holds bytes 1..2)
    always_comb begin
        if (page_bin) begin
            dec_page  = addr_sh[11:0];
            dec_start = {1'b0, byte_q};
        end else begin
            dec_page  = addr_sh[12:1];
            dec_start = {addr_sh[0], byte_q};
        end
    end

    // expected chip-erase byte for the current position in the sequence
    always_comb begin
        case (ce_idx)
            2'd1:    ce_expect = OP_CE1;
            2'd2:    ce_expect = OP_CE2;
            default: ce_expect = OP_CE3;
        endcase
    end

    // command state machine; launches only on chip-select rise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= D_OPC;
            acnt      <= '0;
            addr_sh   <= '0;
            ptr       <= '0;
            ce_idx    <= '0;
            buf_we    <= 1'b0;
            buf_sel   <= 1'b0;
            buf_idx   <= '0;
            buf_wdata <= '0;
            prog_go   <= 1'b0;
            chip_go   <= 1'b0;
            go_sel    <= 1'b0;
            go_page   <= '0;
        end else begin
            buf_we  <= 1'b0;
            prog_go <= 1'b0;
            chip_go <= 1'b0;
            if (!cs_active) begin
                st   <= D_OPC;
                acnt <= '0;
                if (cs_rise && !busy && !prot) begin
                    if (st == D_DATA)    prog_go <= 1'b1;
                    if (st == D_CHIP_OK) chip_go <= 1'b1;
                end
            end else if (byte_vld) begin
                case (st)
                    D_OPC: begin
                        if (busy) begin
                            st <= D_SKIP;
                        end else if (byte_q == OP_PROG_B1 || byte_q == OP_PROG_B2) begin
                            go_sel <= (byte_q == OP_PROG_B2);
                            acnt   <= '0;
                            st     <= D_ADDR;
                        end else if (byte_q == OP_CE0) begin
                            ce_idx <= 2'd1;
                            st     <= D_CHIP;
                        end else begin
                            st <= D_SKIP;
                        end
                    end
                    D_ADDR: begin
                        addr_sh <= {addr_sh[4:0], byte_q};
                        acnt    <= acnt + 2'd1;
                        if (acnt == 2'd2) begin
                            go_page <= dec_page;
                            ptr     <= (dec_start >= page_len) ? 9'd0 : dec_start;
                            st      <= D_DATA;
                        end
                    end
                    D_DATA: begin
                        buf_we    <= 1'b1;
                        buf_sel   <= go_sel;
                        buf_idx   <= ptr;
                        buf_wdata <= byte_q;
                        ptr       <= (ptr == last_idx) ? 9'd0 : ptr + 9'd1;
                    end
                    D_CHIP: begin
                        if (byte_q != ce_expect)  st <= D_SKIP;
                        else if (ce_idx == 2'd3)  st <= D_CHIP_OK;
                        else                      ce_idx <= ce_idx + 2'd1;
                    end
                    D_CHIP_OK: st <= D_SKIP;
                    default:   st <= D_SKIP;
                endcase
            end
        end
    end

    // R4: the write pointer never leaves the current page
    p_ptr_in_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == D_DATA) |-> (ptr < page_len));
    // R10: a launch is never issued while the engine is busy
    p_go_only_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_go || chip_go) |-> !busy);
    // R9: a program launch only follows a complete address
    p_go_after_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        prog_go |-> $past(st == D_DATA));
endmodule

// File: rtl/serflash_engine.sv
// Self-timed erase/program engine with two page buffers, the behavioural
// main array and write-protect latching. Assumes ERASE_CYC, PROG_CYC >= 264
// and CHIP_CYC >= NUM_PAGES*264 so each walk fits inside its phase.
module serflash_engine
    import serflash_pkg::*;
#(
    parameter int NUM_PAGES = 4,
    parameter int ERASE_CYC = 400,
    parameter int PROG_CYC  = 300,
    parameter int CHIP_CYC  = 1200,
    localparam int PG_W   = $clog2(NUM_PAGES),
    localparam int DEPTH  = NUM_PAGES * PAGE_STD,
    localparam int MA_W   = $clog2(DEPTH),
    localparam int MAXC   = (CHIP_CYC > ERASE_CYC)
                            ? ((CHIP_CYC > PROG_CYC) ? CHIP_CYC : PROG_CYC)
                            : ((ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC),
    localparam int TW     = $clog2(MAXC + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            page_bin,
    input  logic            wp_n,
    input  logic            buf_we,
    input  logic            buf_sel,
    input  logic [8:0]      buf_idx,
    input  logic [7:0]      buf_wdata,
    input  logic            prog_go,
    input  logic            chip_go,
    input  logic            go_sel,
    input  logic [11:0]     go_page,
    input  logic [PG_W-1:0] rd_page,
    input  logic [8:0]      rd_byte,
    output logic [7:0]      rd_data,
    output logic            busy,
    output logic            prot
);
    logic [7:0]      bufm [2][PAGE_STD];
    logic [7:0]      mem  [DEPTH];
    eng_st_t         st;
    logic [TW-1:0]   tmr;
    logic [PG_W-1:0] pg_r;
    logic            sel_r;
    logic [8:0]      len_r;
    logic            mem_we;
    logic [MA_W-1:0] mem_waddr;
    logic [7:0]      mem_wdata;

    assign busy = (st != E_IDLE);

    for (genvar b = 0; b < 2; b++) begin : g_buf
        // each buffer takes bytes addressed to it
        always_ff @(posedge clk) begin
            if (buf_we && (buf_sel == 1'(b))) bufm[b][buf_idx] <= buf_wdata;
        end
    end

    // phase sequencing with a cycle counter per phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= E_IDLE;
            tmr   <= '0;
            pg_r  <= '0;
            sel_r <= 1'b0;
            len_r <= 9'(PAGE_STD);
        end else begin
            case (st)
                E_IDLE: begin
                    tmr <= '0;
                    if (prog_go) begin
                        st    <= E_ERASE;
                        pg_r  <= PG_W'(go_page % 12'(NUM_PAGES));
                        sel_r <= go_sel;
                        len_r <= page_bin ? 9'(PAGE_BIN) : 9'(PAGE_STD);
                    end else if (chip_go) begin
                        st <= E_CHIP;
                    end
                end
                E_ERASE: begin
                    if (tmr == TW'(ERASE_CYC - 1)) begin
                        st  <= E_PROG;
                        tmr <= '0;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                E_PROG: begin
                    if (tmr == TW'(PROG_CYC - 1)) begin
                        st  <= E_IDLE;
                        tmr <= '0;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                default: begin
                    if (tmr == TW'(CHIP_CYC - 1)) begin
                        st  <= E_IDLE;
                        tmr <= '0;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
            endcase
        end
    end

    // one array write per cycle: erase walk, copy walk or full-array walk
    always_comb begin
        mem_we    = 1'b0;
        mem_waddr = '0;
        mem_wdata = 8'hFF;
        case (st)
            E_ERASE: begin
                mem_we    = (int'(tmr) < int'(len_r));
                mem_waddr = MA_W'(int'(pg_r) * PAGE_STD + int'(tmr));
            end
            E_PROG: begin
                mem_we    = (int'(tmr) < int'(len_r));
                mem_waddr = MA_W'(int'(pg_r) * PAGE_STD + int'(tmr));
                mem_wdata = bufm[sel_r][tmr[8:0]];
            end
            E_CHIP: begin
                mem_we    = (int'(tmr) < DEPTH);
                mem_waddr = MA_W'(tmr);
            end
            default: ;
        endcase
    end

    // behavioural main array storage
    always_ff @(posedge clk) begin
        if (mem_we) mem[mem_waddr] <= mem_wdata;
    end

    assign rd_data = mem[MA_W'(int'(rd_page) * PAGE_STD + int'(rd_byte))];

    // protect flag follows the pin only while idle
    always_ff @(posedge clk) begin
        if (!rst_n)     prot <= 1'b0;
        else if (!busy) prot <= !wp_n;
    end

    // R5: a launch makes the engine busy on the next cycle
    p_busy_after_go_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_go || chip_go) |=> busy);
    // R5: the copy phase is only entered from the erase phase or itself
    p_prog_after_erase_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == E_PROG) |-> ($past(st == E_ERASE) || $past(st == E_PROG)));
    // R11: protection does not change while an operation runs
    p_prot_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(prot));
    // R6: the erase counter stays inside its phase length
    p_tmr_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == E_ERASE) |-> (int'(tmr) < ERASE_CYC));
endmodule

// File: rtl/serflash_bufprog.sv
// Top of the serial flash buffer-program front end: pin synchronisers, edge
// detection, byte assembly, command decode and the self-timed engine.
// Assumes clk is several times faster than sck.
module serflash_bufprog
    import serflash_pkg::*;
#(
    parameter int NUM_PAGES = 4,
    parameter int ERASE_CYC = 400,
    parameter int PROG_CYC  = 300,
    parameter int CHIP_CYC  = 1200,
    localparam int PG_W = $clog2(NUM_PAGES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sck,
    input  logic            cs_n,
    input  logic            si,
    input  logic            wp_n,
    input  logic            page_bin,
    input  logic [PG_W-1:0] rd_page,
    input  logic [8:0]      rd_byte,
    output logic [7:0]      rd_data,
    output logic [7:0]      status
);
    logic [3:0]  pins_s;
    logic        sck_s, cs_s, si_s, wp_s;
    logic        sck_prev, cs_prev;
    logic        sck_rise, cs_rise, cs_active;
    logic        byte_vld;
    logic [7:0]  byte_q;
    logic        buf_we, buf_sel, prog_go, chip_go, go_sel;
    logic [8:0]  buf_idx;
    logic [7:0]  buf_wdata;
    logic [11:0] go_page;
    logic        busy, prot;

    serflash_sync #(.W(4), .STAGES(2), .RST_VAL(4'b1010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({wp_n, si, cs_n, sck}),
        .q     (pins_s)
    );
    assign {wp_s, si_s, cs_s, sck_s} = pins_s;

    // previous values for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_prev <= 1'b0;
            cs_prev  <= 1'b1;
        end else begin
            sck_prev <= sck_s;
            cs_prev  <= cs_s;
        end
    end

    assign cs_active = !cs_s;
    assign cs_rise   = cs_s && !cs_prev;
    assign sck_rise  = sck_s && !sck_prev && cs_active;

    serflash_byte_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_active (cs_active),
        .sck_rise  (sck_rise),
        .si        (si_s),
        .byte_vld  (byte_vld),
        .byte_q    (byte_q)
    );

    serflash_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_active (cs_active),
        .cs_rise   (cs_rise),
        .byte_vld  (byte_vld),
        .byte_q    (byte_q),
        .page_bin  (page_bin),
        .busy      (busy),
        .prot      (prot),
        .buf_we    (buf_we),
        .buf_sel   (buf_sel),
        .buf_idx   (buf_idx),
        .buf_wdata (buf_wdata),
        .prog_go   (prog_go),
        .chip_go   (chip_go),
        .go_sel    (go_sel),
        .go_page   (go_page)
    );

    serflash_engine #(
        .NUM_PAGES (NUM_PAGES),
        .ERASE_CYC (ERASE_CYC),
        .PROG_CYC  (PROG_CYC),
        .CHIP_CYC  (CHIP_CYC)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .page_bin  (page_bin),
        .wp_n      (wp_s),
        .buf_we    (buf_we),
        .buf_sel   (buf_sel),
        .buf_idx   (buf_idx),
        .buf_wdata (buf_wdata),
        .prog_go   (prog_go),
        .chip_go   (chip_go),
        .go_sel    (go_sel),
        .go_page   (go_page),
        .rd_page   (rd_page),
        .rd_byte   (rd_byte),
        .rd_data   (rd_data),
        .busy      (busy),
        .prot      (prot)
    );

    assign status = {!busy, 5'b0, prot, page_bin};

    // R12: the ready bit drops only after a launch from the decoder
    p_busy_needs_go_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[7]) |-> $past(prog_go || chip_go));
endmodule

// File: tb/tb_serflash_bufprog.sv
module tb_serflash_bufprog;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int EC = 300;
    localparam int PC = 280;
    localparam int CC = 1100;
    localparam int HALF = 2;

    typedef struct packed {
        logic        mode;
        logic [7:0]  op;
        logic [11:0] page;
        logic [8:0]  start;
        logic [7:0]  n;
        logic [7:0]  seed;
    } vec_t;

    // mode, opcode, page, start byte, data count, first data value
    localparam vec_t VECS [5] = '{
        '{1'b0, 8'h82, 12'd2049, 9'd0,   8'd10, 8'h10},  // R2: top page bit, standard split
        '{1'b1, 8'h85, 12'd2050, 9'd250, 8'd12, 8'h40},  // R3, R4: wrap at 256
        '{1'b0, 8'h82, 12'd3,    9'd260, 8'd8,  8'h70},  // R4: wrap at 264
        '{1'b0, 8'h85, 12'd0,    9'd300, 8'd4,  8'hC0},  // R4: start beyond page
        '{1'b1, 8'h82, 12'd5,    9'd0,   8'd3,  8'hE0}   // R5: page modulo
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, wp_n = 1'b1, page_bin = 1'b0;
    logic [1:0] rd_page = '0;
    logic [8:0] rd_byte = '0;
    logic [7:0] rd_data, status;

    int errors = 0;
    int checks = 0;
    int busy_cnt = 0;
    logic [7:0] bufm [2][264];
    logic [7:0] memm [NP][264];

    always #(CLK_PERIOD/2) clk = ~clk;

    serflash_bufprog #(.NUM_PAGES(NP), .ERASE_CYC(EC), .PROG_CYC(PC), .CHIP_CYC(CC)) dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .wp_n(wp_n),
        .page_bin(page_bin), .rd_page(rd_page), .rd_byte(rd_byte),
        .rd_data(rd_data), .status(status)
    );

    always @(posedge clk) if (rst_n && !status[7]) busy_cnt <= busy_cnt + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            si = b[i];
            repeat (HALF) @(negedge clk);
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic cs_start();
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_end();
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic wait_ready();
        int t = 0;
        while (!status[7] && t < 5000) begin
            @(negedge clk);
            t++;
        end
        if (t >= 5000) chk(1'b0, "R6 ready timeout", 0, 1);
    endtask

    function automatic int plen(input logic mode);
        return mode ? 256 : 264;
    endfunction

    // send program command; model buffer writes when upd is set
    task automatic send_prog(input logic [7:0] op, input logic mode, input logic [11:0] pg,
                             input logic [8:0] start, input int n, input logic [7:0] seed,
                             input bit upd);
        logic [23:0] a;
        int p;
        int len = plen(mode);
        a = mode ? {4'b0, pg, start[7:0]} : {3'b0, pg, start};
        p = (int'(mode ? {1'b0, start[7:0]} : start) >= len) ? 0
            : int'(mode ? {1'b0, start[7:0]} : start);
        cs_start();
        send_byte(op);
        send_byte(a[23:16]);
        send_byte(a[15:8]);
        send_byte(a[7:0]);
        for (int i = 0; i < n; i++) begin
            send_byte(seed + 8'(i));
            if (upd) bufm[op == 8'h85][p] = seed + 8'(i);
            p = (p == len - 1) ? 0 : p + 1;
        end
    endtask

    task automatic model_prog(input logic sel, input logic [11:0] pg, input logic mode);
        for (int j = 0; j < plen(mode); j++) memm[pg % NP][j] = bufm[sel][j];
    endtask

    task automatic cmp_page(input int pg, input string req);
        int bad = 0;
        int first_act = 0, first_exp = 0;
        for (int j = 0; j < 264; j++) begin
            rd_page = 2'(pg);
            rd_byte = 9'(j);
            #1;
            if (rd_data !== memm[pg][j]) begin
                if (bad == 0) begin
                    first_act = int'(rd_data);
                    first_exp = int'(memm[pg][j]);
                end
                bad++;
            end
        end
        chk(bad == 0, req, first_act, first_exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R12: reset status
        chk(status == 8'h80, "R12 reset status", status, 8'h80);
        page_bin = 1'b1;
        #1;
        chk(status == 8'h81, "R12 mode bit", status, 8'h81);
        page_bin = 1'b0;

        // R7: full chip erase
        busy_cnt = 0;
        cs_start();
        send_byte(8'hC7); send_byte(8'h94); send_byte(8'h80); send_byte(8'h9A);
        cs_end();
        wait_ready();
        chk(busy_cnt == CC, "R7 chip erase busy length", busy_cnt, CC);
        for (int pg = 0; pg < NP; pg++) begin
            for (int j = 0; j < 264; j++) memm[pg][j] = 8'hFF;
            cmp_page(pg, "R7 page all ones");
        end

        // R1, R5: fill both buffers completely, program pages 0 and 1
        for (int s = 0; s < 2; s++) begin
            busy_cnt = 0;
            send_prog(s == 0 ? 8'h82 : 8'h85, 1'b0, 12'(s), 9'd0, 264, 8'(s * 128), 1'b1);
            cs_end();
            wait_ready();
            model_prog(1'(s), 12'(s), 1'b0);
            chk(busy_cnt == EC + PC, "R6 busy length prime", busy_cnt, EC + PC);
            cmp_page(s, "R1 R5 primed page");
        end

        // vector table walk
        foreach (VECS[v]) begin
            page_bin = VECS[v].mode;
            repeat (4) @(negedge clk);
            busy_cnt = 0;
            send_prog(VECS[v].op, VECS[v].mode, VECS[v].page, VECS[v].start,
                      int'(VECS[v].n), VECS[v].seed, 1'b1);
            cs_end();
            wait_ready();
            model_prog(VECS[v].op == 8'h85, VECS[v].page, VECS[v].mode);
            chk(busy_cnt == EC + PC, "R6 busy length", busy_cnt, EC + PC);
            cmp_page(int'(VECS[v].page % NP), VECS[v].mode ? "R3 R4 R5 vector page" : "R2 R4 R5 vector page");
        end
        page_bin = 1'b0;
        repeat (4) @(negedge clk);

        // R8: wrong last byte of chip erase
        busy_cnt = 0;
        cs_start();
        send_byte(8'hC7); send_byte(8'h94); send_byte(8'h80); send_byte(8'h9B);
        cs_end();
        repeat (10) @(negedge clk);
        chk(busy_cnt == 0, "R8 bad erase no busy", busy_cnt, 0);
        cmp_page(2, "R8 bad erase array kept");

        // R9: truncated address
        busy_cnt = 0;
        cs_start();
        send_byte(8'h82); send_byte(8'h00); send_byte(8'h02);
        cs_end();
        repeat (10) @(negedge clk);
        chk(busy_cnt == 0 && status[7], "R9 short address no launch", busy_cnt, 0);
        cmp_page(1, "R9 short address array kept");

        // R10: command during busy
        busy_cnt = 0;
        send_prog(8'h82, 1'b0, 12'd2, 9'd5, 5, 8'h33, 1'b1);
        cs_end();
        send_prog(8'h85, 1'b0, 12'd3, 9'd0, 3, 8'hA0, 1'b0);
        cs_end();
        wait_ready();
        model_prog(1'b0, 12'd2, 1'b0);
        chk(busy_cnt == EC + PC, "R10 busy length unchanged", busy_cnt, EC + PC);
        cmp_page(2, "R5 first program landed");
        cmp_page(3, "R10 busy command no program");
        busy_cnt = 0;
        send_prog(8'h85, 1'b0, 12'd3, 9'd0, 0, 8'h00, 1'b1);
        cs_end();
        wait_ready();
        model_prog(1'b1, 12'd3, 1'b0);
        cmp_page(3, "R10 buffer 2 untouched while busy");

        // R11: protect raised mid-operation
        send_prog(8'h82, 1'b0, 12'd0, 9'd0, 2, 8'h55, 1'b1);
        cs_end();
        wp_n = 1'b0;
        repeat (20) @(negedge clk);
        chk(status[1] == 1'b0 && status[7] == 1'b0, "R11 protect deferred", status, 8'h00);
        wait_ready();
        model_prog(1'b0, 12'd0, 1'b0);
        repeat (5) @(negedge clk);
        chk(status == 8'h82, "R11 protect after completion", status, 8'h82);
        busy_cnt = 0;
        send_prog(8'h82, 1'b0, 12'd1, 9'd0, 2, 8'h66, 1'b1);
        cs_end();
        repeat (10) @(negedge clk);
        chk(busy_cnt == 0, "R11 protected no launch", busy_cnt, 0);
        cmp_page(1, "R11 protected page kept");
        wp_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(status == 8'h80, "R11 protect released", status, 8'h80);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule